// File: doc/BRIEF.md
# Double-Buffered Frame Scanner

The block holds two frame memories for a monochrome dot-matrix display of COLS by ROWS pixels, packed WORD_W pixels to a word. At any moment one memory is on screen and the other is open to the host. The host fills the hidden memory over a plain write port. When the picture is complete, the host pulses `hostFrameDone`. At the next frame boundary the two memories trade roles. If no completion pulse has arrived, the same memory is shown again.

Readout runs without pause. A bit counter, a column-word counter and a row counter form a chain, each carrying into the next, and together they walk every word of the shown memory in row-major order. Each word goes into a shift register and leaves one pixel at a time on `serData`, with a serial clock `serClk` for the column shift registers of the display. The next word is fetched while the current one is still shifting. `frameSync` marks the start of every frame, so row drivers and latches can align to it.

Top module: `fbSwapScan`

## Requirements
- R1: While `rstN` is low, `serClk`, `serData` and `frameSync` are 0. `serClk` stays low in the first clock cycle after reset is released.
- R2: Each pixel takes one clock cycle with `serClk` low and then one cycle with `serClk` high. `serData` changes only while `serClk` is low, so it is stable across the rising edge of `serClk`.
- R3: A frame sends memory words in address order 0 to COLS*ROWS/WORD_W-1, where address = row*(COLS/WORD_W) + column word. Each word is sent most significant bit first (bit WORD_W-1 first, bit 0 last).
- R4: After the first pixel, `serClk` alternates on every clock cycle with no gap between words or frames. A frame of COLS*ROWS pixels therefore spans exactly 2*COLS*ROWS clock cycles.
- R5: `frameSync` is high for exactly one cycle. That cycle is the low `serClk` phase of the first pixel of a frame. The pulse repeats every 2*COLS*ROWS cycles.
- R6: A `hostFrameDone` pulse during a frame makes the next frame come from the other memory. Several pulses before one boundary produce a single swap.
- R7: Without a `hostFrameDone` pulse, the next frame repeats the memory already shown.
- R8: A host write (`hostWe` high, with `hostAddr` and `hostData`) always lands in the memory that is not shown. It never alters the frame on screen, nor any later frame until the next swap. After reset, memory 0 is shown and memory 1 takes writes.
- R9: The swap decision uses `hostFrameDone` as sampled at the clock edge 2*WORD_W cycles before the edge that raises the next `frameSync`. A pulse sampled at that edge still swaps at that boundary. A pulse sampled one edge later waits one extra frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one pixel every two cycles |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | AW = clog2(COLS*ROWS/WORD_W) | Word address of a host write |
| hostData | input | WORD_W | Pixel word written by the host, leftmost pixel in the MSB |
| hostWe | input | 1 | Host write strobe, one word per cycle |
| hostFrameDone | input | 1 | Host signals that the hidden memory holds a complete frame |
| serData | output | 1 | Serial pixel data |
| serClk | output | 1 | Serial shift clock; data is valid at its rising edge |
| frameSync | output | 1 | One-cycle start-of-frame marker |

## Verification
The hardest case to reach from the ports is a completion pulse that arrives on the exact clock edge where the boundary decision is made, or one edge after it. No port shows that edge directly. The stimulus therefore times the pulse from the observed `frameSync`: it counts 495 and then 496 falling clock edges from the sync and checks that the swap happens at the first boundary in one case and is deferred by one frame in the other. Random rounds add scattered hidden-memory writes and zero, one or two completion pulses per frame, with every captured frame compared against a bench model of both memories.

// File: rtl/fbSwapPkg.sv
package fbSwapPkg;

  // Per-cycle commands from the scan control to the pixel datapath.
  typedef struct packed {
    logic loadWord;   // take the prefetched word into the shifter
    logic shiftBit;   // advance the shifter by one pixel
    logic dispSel;    // memory currently on screen
  } fbStrobe_t;

endpackage

// File: rtl/fbCountStage.sv
// One link of the readout counter chain: counts inc pulses modulo MODULO
// and raises carry on the pulse that wraps it back to zero.
module fbCountStage #(
  parameter int MODULO    = 8,
  parameter int RESET_VAL = 0,
  localparam int W = (MODULO > 1) ? $clog2(MODULO) : 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inc,
  output logic [W-1:0] value,
  output logic         carry
);

  assign carry = inc && (value == W'(MODULO - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      value <= W'(RESET_VAL);
    end else if (inc) begin
      value <= carry ? '0 : value + W'(1);
    end
  end

endmodule

// File: rtl/fbSwapCtrl.sv
// Pixel timing, chained address counters, frame marker and memory swap.
module fbSwapCtrl
  import fbSwapPkg::*;
#(
  parameter int COLS   = 32,
  parameter int ROWS   = 8,
  parameter int WORD_W = 8,
  localparam int WPR = COLS / WORD_W,
  localparam int FW  = WPR * ROWS,
  localparam int AW  = (FW > 1) ? $clog2(FW) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hostFrameDone,
  output fbStrobe_t     strobe,
  output logic [AW-1:0] rdAddr,
  output logic          wrapNow,
  output logic          serClk,
  output logic          frameSync
);

  localparam int BW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam int CW = (WPR > 1) ? $clog2(WPR) : 1;
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;

  logic          phase;      // 0: low half of a pixel, 1: high half
  logic          running;    // first word has reached the shifter
  logic          pendSwap;   // host completion seen, swap not yet taken
  logic          dispSel;
  logic [BW-1:0] bitIdx;
  logic [CW-1:0] colIdx;
  logic [RW-1:0] rowIdx;
  logic          loadWord;
  logic          colCarry;
  logic          swapNow;

  // The bit stage starts on its last value, so the first high phase after
  // reset loads word 0 instead of shifting out an empty word.
  fbCountStage #(.MODULO(WORD_W), .RESET_VAL(WORD_W - 1)) bitStage (
    .clk(clk), .rstN(rstN), .inc(phase), .value(bitIdx), .carry(loadWord)
  );

  fbCountStage #(.MODULO(WPR), .RESET_VAL(0)) colStage (
    .clk(clk), .rstN(rstN), .inc(loadWord), .value(colIdx), .carry(colCarry)
  );

  fbCountStage #(.MODULO(ROWS), .RESET_VAL(0)) rowStage (
    .clk(clk), .rstN(rstN), .inc(colCarry), .value(rowIdx), .carry(wrapNow)
  );

  assign rdAddr  = AW'(rowIdx) * AW'(WPR) + AW'(colIdx);
  assign swapNow = wrapNow && (pendSwap || hostFrameDone);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= 1'b0;
      running   <= 1'b0;
      pendSwap  <= 1'b0;
      dispSel   <= 1'b0;
      frameSync <= 1'b0;
    end else begin
      phase     <= ~phase;
      running   <= running | loadWord;
      frameSync <= loadWord && (rdAddr == '0);
      if (swapNow) begin
        dispSel  <= ~dispSel;
        pendSwap <= 1'b0;
      end else if (hostFrameDone) begin
        pendSwap <= 1'b1;
      end
    end
  end

  assign serClk          = phase && running;
  assign strobe.loadWord = loadWord;
  assign strobe.shiftBit = phase && (bitIdx != BW'(WORD_W - 1));
  assign strobe.dispSel  = dispSel;

endmodule

// File: rtl/fbSwapPath.sv
// Two frame memories, write steering to the hidden one, read of the shown
// one, and the parallel-to-serial shifter.
module fbSwapPath
  import fbSwapPkg::*;
#(
  parameter int COLS   = 32,
  parameter int ROWS   = 8,
  parameter int WORD_W = 8,
  localparam int WPR = COLS / WORD_W,
  localparam int FW  = WPR * ROWS,
  localparam int AW  = (FW > 1) ? $clog2(FW) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [AW-1:0]     hostAddr,
  input  logic [WORD_W-1:0] hostData,
  input  logic              hostWe,
  input  fbStrobe_t         strobe,
  input  logic [AW-1:0]     rdAddr,
  output logic              serData
);

  logic              wrSel;
  logic              addrOk;
  logic [WORD_W-1:0] rdData;
  logic [WORD_W-1:0] shiftReg;

  assign wrSel  = ~strobe.dispSel;
  assign addrOk = (int'(hostAddr) < FW);

  for (genvar b = 0; b < 2; b++) begin : gBank
    logic [WORD_W-1:0] mem [FW];
    logic [WORD_W-1:0] rdWord;

    always_ff @(posedge clk) begin
      if (hostWe && addrOk && (wrSel == 1'(b))) begin
        mem[hostAddr] <= hostData;
      end
      rdWord <= mem[rdAddr];
    end
  end

  assign rdData = strobe.dispSel ? gBank[1].rdWord : gBank[0].rdWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobe.loadWord) begin
      shiftReg <= rdData;
    end else if (strobe.shiftBit) begin
      shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
    end
  end

  assign serData = shiftReg[WORD_W-1];

endmodule

// File: rtl/fbSwapScan.sv
module fbSwapScan
  import fbSwapPkg::*;
#(
  parameter int COLS   = 32,
  parameter int ROWS   = 8,
  parameter int WORD_W = 8,
  localparam int FW = (COLS / WORD_W) * ROWS,
  localparam int AW = (FW > 1) ? $clog2(FW) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [AW-1:0]     hostAddr,
  input  logic [WORD_W-1:0] hostData,
  input  logic              hostWe,
  input  logic              hostFrameDone,
  output logic              serData,
  output logic              serClk,
  output logic              frameSync
);

  fbStrobe_t     ctrlStrobe;
  logic [AW-1:0] rdAddr;
  logic          wrapNow;

  fbSwapCtrl #(.COLS(COLS), .ROWS(ROWS), .WORD_W(WORD_W)) ctrl (
    .clk(clk), .rstN(rstN), .hostFrameDone(hostFrameDone),
    .strobe(ctrlStrobe), .rdAddr(rdAddr), .wrapNow(wrapNow),
    .serClk(serClk), .frameSync(frameSync)
  );

  fbSwapPath #(.COLS(COLS), .ROWS(ROWS), .WORD_W(WORD_W)) path (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostData(hostData),
    .hostWe(hostWe), .strobe(ctrlStrobe), .rdAddr(rdAddr), .serData(serData)
  );

endmodule

// File: rtl/fbSwapChecker.sv
module fbSwapChecker #(
  parameter int FRAME_CYCLES = 512
) (
  input logic clk,
  input logic rstN,
  input logic serData,
  input logic serClk,
  input logic frameSync,
  input logic dispSel,
  input logic wrapNow
);

  int  sinceSync;
  logic syncSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceSync <= 0;
      syncSeen  <= 1'b0;
    end else if (frameSync) begin
      sinceSync <= 1;
      syncSeen  <= 1'b1;
    end else if (sinceSync < FRAME_CYCLES + 2) begin
      sinceSync <= sinceSync + 1;
    end
  end

  assert_data_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    serClk |-> $stable(serData));

  assert_high_then_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    serClk |=> !serClk);

  assert_low_then_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(serClk) |=> serClk);

  assert_sync_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |=> !frameSync);

  assert_sync_low_phase_R5: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |-> !serClk);

  assert_sync_period_R5: assert property (@(posedge clk) disable iff (!rstN)
    (frameSync && syncSeen) |-> (sinceSync == FRAME_CYCLES));

  assert_swap_on_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    (dispSel != $past(dispSel)) |-> $past(wrapNow));

endmodule

bind fbSwapScan fbSwapChecker #(.FRAME_CYCLES(2 * COLS * ROWS)) chk (
  .clk(clk), .rstN(rstN), .serData(serData), .serClk(serClk),
  .frameSync(frameSync), .dispSel(ctrlStrobe.dispSel), .wrapNow(wrapNow)
);

// File: tb/fbSwapScan_test.sv
module fbSwapScan_test;
  localparam int COLS = 32, ROWS = 8, WW = 8;
  localparam int FW = COLS * ROWS / WW;
  localparam int FB = COLS * ROWS;
  localparam int AW = $clog2(FW);
  localparam int FRAME_CYC = 2 * FB;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic [WW-1:0] hostData = '0;
  logic hostWe = 1'b0;
  logic hostFrameDone = 1'b0;
  logic serData, serClk, frameSync;

  int checks = 0;
  int errors = 0;
  logic [WW-1:0] model [2][FW];
  int dispModel = 0;
  logic [FB-1:0] got;
  int span;

  always #2 clk = ~clk;

  fbSwapScan #(.COLS(COLS), .ROWS(ROWS), .WORD_W(WW)) uut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostData(hostData),
    .hostWe(hostWe), .hostFrameDone(hostFrameDone),
    .serData(serData), .serClk(serClk), .frameSync(frameSync)
  );

  task automatic checkVal(string req, string what, logic [FB-1:0] act, logic [FB-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [FB-1:0] expFrame(int b);
    logic [FB-1:0] bits = '0;
    for (int w = 0; w < FW; w++)
      for (int i = 0; i < WW; i++)
        bits[w*WW+i] = model[b][w][WW-1-i];
    return bits;
  endfunction

  // Sync width and period, watched on every falling edge (R5).
  int cyc = 0, lastSync = -1;
  logic prevSync = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      if (frameSync && prevSync) checkVal("R5", "sync width", 2, 1);
      if (frameSync) begin
        if (lastSync >= 0) checkVal("R5", "sync period", FB'(cyc - lastSync), FB'(FRAME_CYC));
        lastSync = cyc;
      end
      prevSync = frameSync;
    end
  end

  // Capture one frame: waits for frameSync, then takes serData at each
  // sampled high phase of serClk.
  task automatic grabFrame(output logic [FB-1:0] bits, output int cycles);
    bits = '0;
    do @(negedge clk); while (!frameSync);
    cycles = 0;
    for (int k = 0; k < FB; k++) begin
      do begin @(negedge clk); cycles++; end while (!serClk);
      bits[k] = serData;
    end
  endtask

  task automatic hostWrite(int addr, logic [WW-1:0] data);
    hostAddr = AW'(addr);
    hostData = data;
    hostWe = 1'b1;
    model[1-dispModel][addr] = data;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic fillHidden(int n, bit full);
    for (int i = 0; i < n; i++)
      hostWrite(full ? i : int'($urandom % FW), WW'($urandom));
  endtask

  task automatic pulseDone();
    hostFrameDone = 1'b1;
    @(negedge clk);
    hostFrameDone = 1'b0;
  endtask

  task automatic expectShown(string req, string what);
    checkVal(req, what, got, expFrame(dispModel));
    checkVal("R4", "frame span", FB'(span), FB'(FRAME_CYC - 1));
  endtask

  bit finished = 1'b0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R4 watchdog: actual hung expected finished run");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    checkVal("R1", "serClk in reset", FB'(serClk), 0);
    checkVal("R1", "serData in reset", FB'(serData), 0);
    checkVal("R1", "frameSync in reset", FB'(frameSync), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R1", "serClk first cycle", FB'(serClk), 0);

    // R8 / R6: fill memory 1 while memory 0 shows, then hand it over.
    fillHidden(FW, 1'b1);
    pulseDone();
    dispModel = 1;
    grabFrame(got, span);
    expectShown("R3", "first handed-over frame");

    // R8: overwrite every word of the hidden memory during display.
    fork
      grabFrame(got, span);
      begin repeat (10) @(negedge clk); fillHidden(FW, 1'b1); end
    join
    expectShown("R8", "frame during hidden writes");
    grabFrame(got, span);
    expectShown("R7", "repeat without completion");

    // R6: one completion pulse mid-frame.
    fork
      grabFrame(got, span);
      begin repeat (50) @(negedge clk); pulseDone(); end
    join
    expectShown("R7", "frame before swap");
    dispModel = 0;
    grabFrame(got, span);
    expectShown("R6", "swapped frame");

    // R9: pulse sampled on the decision edge swaps at this boundary.
    do @(negedge clk); while (!frameSync);
    repeat (495) @(negedge clk);
    pulseDone();
    dispModel = 1;
    grabFrame(got, span);
    expectShown("R9", "pulse on decision edge");

    // R9: pulse one edge later is deferred by one frame.
    do @(negedge clk); while (!frameSync);
    repeat (496) @(negedge clk);
    pulseDone();
    grabFrame(got, span);
    expectShown("R9", "late pulse not yet taken");
    dispModel = 0;
    grabFrame(got, span);
    expectShown("R9", "late pulse taken next frame");

    // Random rounds: scattered writes, zero to two completion pulses.
    for (int r = 0; r < 10; r++) begin
      int nWr = 1 + int'($urandom % 40);
      int nDone = int'($urandom % 3);
      fork
        grabFrame(got, span);
        begin
          repeat (20) @(negedge clk);
          fillHidden(nWr, 1'b0);
          for (int d = 0; d < nDone; d++) begin
            repeat (3) @(negedge clk);
            pulseDone();
          end
        end
      join
      expectShown("R8", "random round frame");
      if (nDone > 0) dispModel = 1 - dispModel;
    end
    grabFrame(got, span);
    expectShown("R6", "after random rounds");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule